// File: doc/BRIEF.md
# Stereo Audio Serial Master Receiver

This block is the clock master and data receiver for a stereo audio converter that sends serial samples. It runs from one system clock at 256 times the sample rate. From that clock it makes a bit clock at 64 times the sample rate and a frame clock at the sample rate. Both clocks run without a break from the moment reset is released, so the converter never loses lock. Within one frame the frame clock is high for one 32-bit slot and low for the other. The level of the frame clock says which channel the slot carries.

The converter sends each sample MSB first, in the left-justified layout. The sample starts in the first bit-clock period of its slot, with no one-bit lead-in. The block shifts in the leading 24 bits of each slot and throws away the padding bits that follow. Once per frame it presents the left and right samples together on parallel outputs, with a single-cycle strobe. Everything works in the system clock domain. The bit clock and frame clock are registered outputs of one divider. Serial data is sampled on the system edge where the bit clock rises. As an example, a 48 kHz sample rate needs a 12.288 MHz system clock and gives a 3.072 MHz bit clock.

Top module: `stereo_adc_master_rx`

## Requirements
- R1: `bck_o` has a period of 4 system clocks. It is low for the first two cycles of each period and high for the last two. After reset release it starts low, and its first rising edge comes two system clocks after release.
- R2: `lrck_o` holds each level for exactly 128 system clocks (32 bit clocks), so a frame is 256 system clocks. The clock never stops while reset is deasserted.
- R3: `lrck_o` changes only in the same system cycle in which `bck_o` falls.
- R4: `lrck_o` is high (1) during the left slot and low (0) during the right slot. Reset puts the block at the start of a left slot with `lrck_o` = 1.
- R5: `adc_sdata_i` is sampled on the system edge at which `bck_o` rises. The bit sampled in the first bit-clock period after a frame clock edge is bit 23 (the MSB) of that slot's sample. The next 23 periods supply bits 22 down to 0.
- R6: Bit-clock periods 25 to 32 of each slot are ignored, and their data has no effect on the outputs. `left_o` and `right_o` change only in the cycle in which `valid_o` is high.
- R7: `valid_o` is high for exactly one system clock per frame, during the right slot. It rises one system clock after the `bck_o` rising edge that samples the 24th right-channel bit, which is system cycle 223 of the frame counted from 0 at the frame start. In that cycle it presents the left and right samples of the same frame.
- R8: While reset is asserted, `valid_o`, `left_o` and `right_o` are 0. A reset in the middle of a frame discards the partial samples. The first strobe after release comes only after a complete left slot and then a complete right slot have been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_sdata_i | input | 1 | Serial sample data from the converter |
| bck_o | output | 1 | Bit clock to the converter, system clock divided by 4 |
| lrck_o | output | 1 | Frame clock to the converter, high selects the left slot |
| left_o | output | 24 | Left-channel sample, updated with the strobe |
| right_o | output | 24 | Right-channel sample, updated with the strobe |
| valid_o | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
The bench feeds sample words that have only their top or bottom bit set, alternating patterns and random values, so that a design sampling one bit early or late shows up as a shifted or sign-flipped word. Random junk in the padding bits catches a design that shifts past bit 24 and pushes real data out of the word. Exact cycle positions of both clocks and of the strobe are checked on every cycle. An off-by-one in the divider, a frame clock that switches on the wrong bit-clock edge, or a strobe in the wrong slot is therefore reported. Two resets in mid-frame, one in each slot, catch a design that keeps a stale half-frame and reports it early, or that does not restart its clocks from the left slot.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

   // Channel carried by the current slot of a frame
   typedef enum logic {
      SLOT_LEFT  = 1'b0,
      SLOT_RIGHT = 1'b1
   } slot_e;

   // Frame clock level that marks a given slot for a chosen polarity
   function automatic logic frame_level(input slot_e slot, input bit left_high);
      return (slot == SLOT_LEFT) ? left_high : ~left_high;
   endfunction

endpackage

// File: rtl/sarx_timing.sv
module sarx_timing
   import sarx_pkg::*;
#(
   parameter int SYS_PER_BCK    = 4,
   parameter int BCK_PER_SLOT   = 32,
   parameter bit LEFT_LRCK_HIGH = 1'b1,
   localparam int PW = (SYS_PER_BCK  > 1) ? $clog2(SYS_PER_BCK)  : 1,
   localparam int BW = (BCK_PER_SLOT > 1) ? $clog2(BCK_PER_SLOT) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          bck_o,
   output logic          lrck_o,
   output logic          smp_stb_o,
   output logic [BW-1:0] bit_idx_o,
   output slot_e         slot_o
);

   localparam int HALF = SYS_PER_BCK / 2;

   logic [PW-1:0] phase_q, phase_n;
   logic [BW-1:0] bit_q, bit_n;
   slot_e         slot_q, slot_n;
   logic          phase_last, bit_last;
   logic          bck_q, lrck_q, lrck_n;

   assign phase_last = (phase_q == PW'(SYS_PER_BCK - 1));
   assign bit_last   = (bit_q   == BW'(BCK_PER_SLOT - 1));

   always_comb begin
      phase_n = phase_last ? '0 : phase_q + PW'(1);
      bit_n   = bit_q;
      slot_n  = slot_q;
      if (phase_last) begin
         bit_n = bit_last ? '0 : bit_q + BW'(1);
         if (bit_last) begin
            slot_n = (slot_q == SLOT_LEFT) ? SLOT_RIGHT : SLOT_LEFT;
         end
      end
   end

   // Frame clock polarity variant
   generate
      if (LEFT_LRCK_HIGH) begin : g_left_high
         assign lrck_n = (slot_n == SLOT_LEFT);
      end else begin : g_left_low
         assign lrck_n = (slot_n == SLOT_RIGHT);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         bit_q   <= '0;
         slot_q  <= SLOT_LEFT;
         bck_q   <= 1'b0;
         lrck_q  <= frame_level(SLOT_LEFT, LEFT_LRCK_HIGH);
      end else begin
         phase_q <= phase_n;
         bit_q   <= bit_n;
         slot_q  <= slot_n;
         bck_q   <= (phase_n >= PW'(HALF));
         lrck_q  <= lrck_n;
      end
   end

   assign bck_o     = bck_q;
   assign lrck_o    = lrck_q;
   // Last system cycle before the bit clock rises
   assign smp_stb_o = (phase_q == PW'(HALF - 1));
   assign bit_idx_o = bit_q;
   assign slot_o    = slot_q;

endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
   import sarx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int BW       = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sdata_i,
   input  logic                smp_stb_i,
   input  logic [BW-1:0]       bit_idx_i,
   input  slot_e               slot_i,
   output logic [SAMPLE_W-1:0] word_o,
   output logic                done_o,
   output slot_e               done_slot_o
);

   logic [SAMPLE_W-1:0] shift_q, word_q;
   logic                done_q;
   slot_e               done_slot_q;
   logic                in_word, last_bit;

   // Only the leading SAMPLE_W bits of a slot are data
   assign in_word  = ({1'b0, bit_idx_i} < (BW+1)'(SAMPLE_W));
   assign last_bit = (bit_idx_i == BW'(SAMPLE_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q     <= '0;
         word_q      <= '0;
         done_q      <= 1'b0;
         done_slot_q <= SLOT_LEFT;
      end else begin
         done_q <= 1'b0;
         if (smp_stb_i && in_word) begin
            shift_q <= {shift_q[SAMPLE_W-2:0], sdata_i};
         end
         if (smp_stb_i && last_bit) begin
            word_q      <= {shift_q[SAMPLE_W-2:0], sdata_i};
            done_q      <= 1'b1;
            done_slot_q <= slot_i;
         end
      end
   end

   assign word_o      = word_q;
   assign done_o      = done_q;
   assign done_slot_o = done_slot_q;

endmodule

// File: rtl/sarx_frame_out.sv
module sarx_frame_out
   import sarx_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] word_i,
   input  logic                done_i,
   input  slot_e               done_slot_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);

   logic [SAMPLE_W-1:0] left_hold_q, left_q, right_q;
   logic                have_left_q, valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold_q <= '0;
         have_left_q <= 1'b0;
         left_q      <= '0;
         right_q     <= '0;
         valid_q     <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (done_i && (done_slot_i == SLOT_LEFT)) begin
            left_hold_q <= word_i;
            have_left_q <= 1'b1;
         end else if (done_i && (done_slot_i == SLOT_RIGHT) && have_left_q) begin
            left_q      <= left_hold_q;
            right_q     <= word_i;
            valid_q     <= 1'b1;
            have_left_q <= 1'b0;
         end
      end
   end

   assign left_o  = left_q;
   assign right_o = right_q;
   assign valid_o = valid_q;

endmodule

// File: rtl/stereo_adc_master_rx.sv
module stereo_adc_master_rx
   import sarx_pkg::*;
#(
   parameter int SYS_PER_BCK    = 4,
   parameter int BCK_PER_SLOT   = 32,
   parameter int SAMPLE_W       = 24,
   parameter bit LEFT_LRCK_HIGH = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adc_sdata_i,
   output logic                bck_o,
   output logic                lrck_o,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);

   localparam int BW = (BCK_PER_SLOT > 1) ? $clog2(BCK_PER_SLOT) : 1;

   // Elaboration-time parameter checks
   generate
      if ((SYS_PER_BCK < 2) || (SYS_PER_BCK % 2 != 0)) begin : g_bad_div
         $error("SYS_PER_BCK must be even and at least 2");
      end
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("SAMPLE_W must be at least 2");
      end
      if (SAMPLE_W > BCK_PER_SLOT) begin : g_bad_slot
         $error("SAMPLE_W must fit inside one slot");
      end
   endgenerate

   logic          smp_stb;
   logic [BW-1:0] bit_idx;
   slot_e         slot;
   logic [SAMPLE_W-1:0] word;
   logic          done;
   slot_e         done_slot;

   sarx_timing #(
      .SYS_PER_BCK   (SYS_PER_BCK),
      .BCK_PER_SLOT  (BCK_PER_SLOT),
      .LEFT_LRCK_HIGH(LEFT_LRCK_HIGH)
   ) u_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .bck_o    (bck_o),
      .lrck_o   (lrck_o),
      .smp_stb_o(smp_stb),
      .bit_idx_o(bit_idx),
      .slot_o   (slot)
   );

   sarx_deser #(
      .SAMPLE_W(SAMPLE_W),
      .BW      (BW)
   ) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .sdata_i    (adc_sdata_i),
      .smp_stb_i  (smp_stb),
      .bit_idx_i  (bit_idx),
      .slot_i     (slot),
      .word_o     (word),
      .done_o     (done),
      .done_slot_o(done_slot)
   );

   sarx_frame_out #(
      .SAMPLE_W(SAMPLE_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_i     (word),
      .done_i     (done),
      .done_slot_i(done_slot),
      .left_o     (left_o),
      .right_o    (right_o),
      .valid_o    (valid_o)
   );

endmodule

// File: rtl/sarx_chk.sv
module sarx_chk #(
   parameter int SYS_PER_BCK    = 4,
   parameter int BCK_PER_SLOT   = 32,
   parameter int SAMPLE_W       = 24,
   parameter bit LEFT_LRCK_HIGH = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bck_o,
   input logic                lrck_o,
   input logic [SAMPLE_W-1:0] left_o,
   input logic [SAMPLE_W-1:0] right_o,
   input logic                valid_o
);

   localparam int HALF     = SYS_PER_BCK / 2;
   localparam int SLOT_SYS = SYS_PER_BCK * BCK_PER_SLOT;
   localparam int CW       = $clog2(SLOT_SYS + 1) + 1;

   logic          bck_d, lrck_d;
   logic [CW-1:0] brun, lrun;

   // Run-length counters of the current clock levels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bck_d  <= 1'b0;
         lrck_d <= LEFT_LRCK_HIGH;
         brun   <= '0;
         lrun   <= '0;
      end else begin
         bck_d  <= bck_o;
         lrck_d <= lrck_o;
         brun   <= (bck_o  != bck_d)  ? CW'(1) : brun + CW'(1);
         lrun   <= (lrck_o != lrck_d) ? CW'(1) : lrun + CW'(1);
      end
   end

   AST_BCK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (bck_o != bck_d) |-> (brun == CW'(HALF)));  // R1
   AST_BCK_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      brun <= CW'(HALF));  // R1
   AST_LRCK_SLOT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (lrck_o != lrck_d) |-> (lrun == CW'(SLOT_SYS)));  // R2
   AST_LRCK_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      lrun <= CW'(SLOT_SYS));  // R2
   AST_LRCK_ON_BCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (lrck_o != lrck_d) |-> (bck_d && !bck_o));  // R3
   AST_VALID_IN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (lrck_o == !LEFT_LRCK_HIGH));  // R7
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);  // R7
   AST_OUT_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));  // R6

endmodule

bind stereo_adc_master_rx sarx_chk #(
   .SYS_PER_BCK   (SYS_PER_BCK),
   .BCK_PER_SLOT  (BCK_PER_SLOT),
   .SAMPLE_W      (SAMPLE_W),
   .LEFT_LRCK_HIGH(LEFT_LRCK_HIGH)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .bck_o  (bck_o),
   .lrck_o (lrck_o),
   .left_o (left_o),
   .right_o(right_o),
   .valid_o(valid_o)
);

// File: tb/stereo_adc_master_rx_tb.sv
module stereo_adc_master_rx_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sdata = 1'b0;
   logic        bck, lrck, valid;
   logic [23:0] left, right;

   always #2 clk = ~clk;

   stereo_adc_master_rx u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .adc_sdata_i(sdata),
      .bck_o      (bck),
      .lrck_o     (lrck),
      .left_o     (left),
      .right_o    (right),
      .valid_o    (valid)
   );

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   bit          done_run = 1'b0;

   // System edges since reset release
   int unsigned n;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) n <= 0;
      else        n <= n + 1;
   end

   task automatic check(input bit ok, input string req,
                        input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at n=%0d", req, act, exp, n);
      end
   endtask

   function automatic logic exp_bck(input int unsigned k);
      return (k % 4) >= 2;
   endfunction
   function automatic logic exp_lrck(input int unsigned k);
      return (k % 256) < 128;
   endfunction
   function automatic logic exp_valid(input int unsigned k);
      return (k % 256) == 223;
   endfunction
   function automatic logic [47:0] directed_pair(input int idx);
      case (idx)
         0:       return {24'h800000, 24'h7FFFFF};
         1:       return {24'hFFFFFF, 24'h000000};
         2:       return {24'hAAAAAA, 24'h555555};
         3:       return {24'h000001, 24'h800001};
         default: return {24'h000000, 24'hFFFFFF};
      endcase
   endfunction

   logic [23:0] cur_l, cur_r, last_l, last_r;
   int          fidx = 0;
   bit          seen_valid = 1'b0;
   logic        prev_bck = 1'b0;

   initial begin
      void'($urandom(32'd2024));
   end

   // Monitor and converter model, both away from the rising edge
   always @(negedge clk) begin
      if (!done_run) begin
         if (!rst_n) begin
            check(valid == 1'b0 && left == '0 && right == '0, "R8 reset outputs",
                  {valid, left[22:0], right}, 48'h0);
            check(bck == 1'b0 && lrck == 1'b1, "R4 reset clocks", {bck, lrck}, 48'h1);
            seen_valid = 1'b0;
         end else begin
            check(bck == exp_bck(n), "R1 bck level", bck, exp_bck(n));
            check(lrck == exp_lrck(n), "R2 R4 lrck level", lrck, exp_lrck(n));
            if ((n % 128) == 0 && n != 0)
               check(prev_bck == 1'b1 && bck == 1'b0, "R3 lrck edge on bck fall",
                     {prev_bck, bck}, 48'h2);
            check(valid == exp_valid(n), "R7 valid timing", valid, exp_valid(n));
            if (valid) begin
               check(left == cur_l, "R5 left sample", left, cur_l);
               check(right == cur_r, "R5 right sample", right, cur_r);
               last_l = left;
               last_r = right;
               seen_valid = 1'b1;
            end else if (seen_valid) begin
               check(left == last_l && right == last_r, "R6 outputs held",
                     {left, right}, {last_l, last_r});
            end else begin
               check(left == '0 && right == '0, "R8 no early data",
                     {left, right}, 48'h0);
            end
         end
         prev_bck = bck;

         // New frame words at the start of each frame
         if ((n % 256) == 0) begin
            if (fidx < 5) begin
               {cur_l, cur_r} = directed_pair(fidx);
            end else begin
               cur_l = 24'($urandom);
               cur_r = 24'($urandom);
            end
            if (rst_n) fidx++;
         end
         // Data changes only where the bit clock falls
         if ((n % 4) == 0) begin
            if (((n % 128) / 4) < 24) begin
               if ((n % 256) < 128) sdata = cur_l[23 - ((n % 128) / 4)];
               else                 sdata = cur_r[23 - ((n % 128) / 4)];
            end else begin
               sdata = 1'($urandom);   // padding junk, R6
            end
         end
      end
   end

   task automatic finish_run();
      done_run = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic reset_at(input int unsigned pos);
      while ((n % 256) != pos) @(negedge clk);
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (20 * 256) @(negedge clk);
      reset_at(200);          // mid right slot, R8
      repeat (6 * 256) @(negedge clk);
      reset_at(60);           // mid left slot, R8
      repeat (6 * 256) @(negedge clk);
      @(negedge clk);
      finish_run();
   end

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

endmodule